// File: doc/BRIEF.md
# Bus-Master DMA Register Bank

This block holds the control and status registers that a host uses to run bus-master DMA on two independent disk channels. Each channel has a command byte, a status byte and a 32-bit pointer to a descriptor table in memory. The host reaches them through a simple byte-addressed port that carries a transfer size. The block turns the host's writes into start and abort requests for the DMA engine of that channel. It also takes a completion strobe from the engine and keeps the channel's status and interrupt line up to date.

A host write that sets the run bit sends a one-cycle start pulse. The pulse carries the channel's descriptor pointer and the device currently selected on that channel. A host write that clears the run bit sends a one-cycle abort pulse to the selected device. The active flag in the status byte belongs to the hardware. The interrupt and error flags are cleared by writing a one to them. The data direction in the command byte cannot change while a transfer is running. The DMA engine and descriptor fetching are outside this block.

Top module: `bmdma_regs`

## Requirements
- R1: Synchronous reset sets both command bytes to 0x00, both status bytes to 0x60 and both pointers to 0. It also leaves the irq outputs low and emits no pulses.
- R2: Channel 0 has its command byte at offset 0x0, its status byte at 0x2 and its pointer at 0x4..0x7 (little-endian). Channel 1 uses 0x8, 0xA and 0xC..0xF. A read returns 1, 2 or 4 bytes from the addressed byte upward for size codes 0, 1 and 2, packed little-endian into rdata with the upper bytes zero. Unmapped bytes and bytes past offset 0xF read as zero.
- R3: A host write that takes command bit 0 (run) from 0 to 1 sets status bit 0 (active). In the next cycle it raises dma_start for that channel for one cycle, with dma_ptr holding that channel's pointer and dma_dev holding the dev_sel bit sampled at the write.
- R4: A host write that takes the run bit from 1 to 0 clears the active bit. In the next cycle it raises dma_abort for that channel for one cycle, with dma_dev holding the dev_sel bit sampled at the write.
- R5: While the run bit is set, a command write leaves command bit 3 (direction) at its old value. While the run bit is clear, bit 3 takes the written value.
- R6: Host writes to the status byte never change bit 0 (active).
- R7: Status bit 2 (interrupt) and bit 1 (error) clear when written with 1 and keep their value when written with 0. Status bits 7:3 take the written value.
- R8: A high dma_done for a channel clears that channel's run and active bits and sets its interrupt bit in the next cycle. If a host command write to the same channel lands in that cycle, the completion wins and no start or abort pulse is emitted.
- R9: Command and status writes take effect only with size code 0, and pointer writes only with size code 2 at the pointer's base offset. Other writes are ignored. A pointer write stores bits 1:0 as zero.
- R10: irq for each channel is high exactly while that channel's interrupt status bit is set.
- R11: Writes, pulses and completions on one channel leave the other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 4 | Host byte address |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| wdata | input | 32 | Host write data, byte 0 in bits 7:0 |
| rdata | output | 32 | Host read data, combinational from addr and size |
| dev_sel | input | 2 | Selected device per channel (bit c for channel c) |
| dma_done | input | 2 | Transfer-complete strobe per channel |
| dma_start | output | 2 | One-cycle start request per channel |
| dma_abort | output | 2 | One-cycle abort request per channel |
| dma_ptr | output | 64 | Descriptor pointer per channel, bits 32c+31:32c, valid with dma_start |
| dma_dev | output | 2 | Device the start or abort is aimed at, per channel |
| irq | output | 2 | Interrupt request per channel |

## Verification
The hardest case is a completion strobe and a host stop write landing in the same clock. It arises only when the engine finishes exactly as software gives up. The bench first starts a channel and then drives dma_done and the stop write on the same falling edge. The scoreboard holds no entry for that edge, so any abort pulse counts as an unexpected event. The status readback must then show the interrupt set and the active bit clear. The frozen direction bit and the write-one-to-clear flags are reached by writing deliberately conflicting values to a running channel and reading them back.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int CH_SPAN = 8;

    localparam logic [2:0] OFF_CMD = 3'd0;
    localparam logic [2:0] OFF_STS = 3'd2;
    localparam logic [2:0] OFF_PTR = 3'd4;

    localparam int CMD_RUN = 0;
    localparam int CMD_DIR = 3;
    localparam int STS_ACT = 0;
    localparam int STS_ERR = 1;
    localparam int STS_INT = 2;

    localparam logic [7:0] STS_RESET = 8'h60;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [7:0]  sts;
        logic [31:0] ptr;
    } chan_regs_t;

    typedef struct packed {
        logic cmd_we;
        logic sts_we;
        logic ptr_we;
    } chan_wr_t;

    function automatic int size_bytes(xfer_size_e s);
        case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            SZ_WORD: return 4;
            default: return 0;
        endcase
    endfunction

    // Command merge: direction is held while a transfer runs.
    function automatic logic [7:0] merge_cmd(logic [7:0] cur, logic [7:0] wr);
        logic [7:0] nv;
        nv = wr;
        if (cur[CMD_RUN]) nv[CMD_DIR] = cur[CMD_DIR];
        return nv;
    endfunction

    // Status merge: active is hardware-owned, interrupt/error clear on one.
    function automatic logic [7:0] merge_sts(logic [7:0] cur, logic [7:0] wr);
        logic [7:0] nv;
        nv          = wr;
        nv[STS_ACT] = cur[STS_ACT];
        nv[STS_ERR] = cur[STS_ERR] & ~wr[STS_ERR];
        nv[STS_INT] = cur[STS_INT] & ~wr[STS_INT];
        return nv;
    endfunction

endpackage

// File: rtl/bmdma_wdec.sv
module bmdma_wdec
    import bmdma_pkg::*;
#(
    parameter int NCH = 2,
    localparam int AW = $clog2(NCH * CH_SPAN)
) (
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [1:0]            size,
    output chan_wr_t [NCH-1:0]    wr
);

    xfer_size_e sz;
    logic [2:0] off;
    logic [AW-4:0] ch_idx;

    assign sz     = xfer_size_e'(size);
    assign off    = addr[2:0];
    assign ch_idx = addr[AW-1:3];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit          = wr_en && (int'(ch_idx) == c);
        assign wr[c].cmd_we = hit && (off == OFF_CMD) && (sz == SZ_BYTE);
        assign wr[c].sts_we = hit && (off == OFF_STS) && (sz == SZ_BYTE);
        assign wr[c].ptr_we = hit && (off == OFF_PTR) && (sz == SZ_WORD);
    end

endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel
    import bmdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  chan_wr_t    wr,
    input  logic [31:0] wdata,
    input  logic        dev_sel,
    input  logic        done,
    output chan_regs_t  regs,
    output logic        start_pulse,
    output logic        abort_pulse,
    output logic [31:0] ev_ptr,
    output logic        ev_dev
);

    chan_regs_t regs_nxt;
    logic       go;
    logic       halt;

    always_comb begin
        logic [7:0] nc;
        regs_nxt = regs;
        go       = 1'b0;
        halt     = 1'b0;
        nc       = regs.cmd;
        if (wr.cmd_we) begin
            nc           = merge_cmd(regs.cmd, wdata[7:0]);
            go           = ~regs.cmd[CMD_RUN] & nc[CMD_RUN];
            halt         = regs.cmd[CMD_RUN] & ~nc[CMD_RUN];
            regs_nxt.cmd = nc;
        end
        if (wr.sts_we) regs_nxt.sts = merge_sts(regs.sts, wdata[7:0]);
        if (wr.ptr_we) regs_nxt.ptr = {wdata[31:2], 2'b00};
        if (go)        regs_nxt.sts[STS_ACT] = 1'b1;
        if (halt)      regs_nxt.sts[STS_ACT] = 1'b0;
        if (done) begin
            regs_nxt.cmd[CMD_RUN] = 1'b0;
            regs_nxt.sts[STS_ACT] = 1'b0;
            regs_nxt.sts[STS_INT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs        <= '{cmd: 8'h00, sts: STS_RESET, ptr: 32'h0};
            start_pulse <= 1'b0;
            abort_pulse <= 1'b0;
            ev_ptr      <= 32'h0;
            ev_dev      <= 1'b0;
        end else begin
            regs        <= regs_nxt;
            start_pulse <= go & ~done;
            abort_pulse <= halt & ~done;
            if ((go | halt) & ~done) ev_dev <= dev_sel;
            if (go & ~done)          ev_ptr <= regs.ptr;
        end
    end

endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
    import bmdma_pkg::*;
#(
    parameter int NCH = 2,
    localparam int NBYTES = NCH * CH_SPAN,
    localparam int AW = $clog2(NBYTES)
) (
    input  logic [NBYTES-1:0][7:0] bank,
    input  logic [AW-1:0]          addr,
    input  logic [1:0]             size,
    output logic [31:0]            rdata
);

    always_comb begin
        int nb;
        nb    = size_bytes(xfer_size_e'(size));
        rdata = 32'h0;
        for (int k = 0; k < 4; k++) begin
            int idx;
            idx = int'(addr) + k;
            if (k < nb && idx < NBYTES)
                rdata[k*8 +: 8] = bank[idx[AW-1:0]];
        end
    end

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int NCH = 2,
    localparam int AW = $clog2(NCH * CH_SPAN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NCH-1:0]    dev_sel,
    input  logic [NCH-1:0]    dma_done,
    output logic [NCH-1:0]    dma_start,
    output logic [NCH-1:0]    dma_abort,
    output logic [NCH*32-1:0] dma_ptr,
    output logic [NCH-1:0]    dma_dev,
    output logic [NCH-1:0]    irq
);

    localparam int NBYTES = NCH * CH_SPAN;

    chan_wr_t   [NCH-1:0]      wr;
    chan_regs_t [NCH-1:0]      regs;
    logic       [NCH-1:0][7:0] cmd_q;
    logic       [NCH-1:0][7:0] sts_q;
    logic       [NBYTES-1:0][7:0] bank;

    bmdma_wdec #(.NCH(NCH)) u_wdec (
        .wr_en (wr_en),
        .addr  (addr),
        .size  (size),
        .wr    (wr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        bmdma_channel u_chan (
            .clk         (clk),
            .rst         (rst),
            .wr          (wr[c]),
            .wdata       (wdata),
            .dev_sel     (dev_sel[c]),
            .done        (dma_done[c]),
            .regs        (regs[c]),
            .start_pulse (dma_start[c]),
            .abort_pulse (dma_abort[c]),
            .ev_ptr      (dma_ptr[c*32 +: 32]),
            .ev_dev      (dma_dev[c])
        );

        assign cmd_q[c] = regs[c].cmd;
        assign sts_q[c] = regs[c].sts;
        assign irq[c]   = regs[c].sts[STS_INT];

        for (genvar b = 0; b < CH_SPAN; b++) begin : g_byte
            if (b == int'(OFF_CMD)) begin : g_cmd
                assign bank[c*CH_SPAN + b] = regs[c].cmd;
            end else if (b == int'(OFF_STS)) begin : g_sts
                assign bank[c*CH_SPAN + b] = regs[c].sts;
            end else if (b >= int'(OFF_PTR)) begin : g_ptr
                assign bank[c*CH_SPAN + b] = regs[c].ptr[(b-int'(OFF_PTR))*8 +: 8];
            end else begin : g_gap
                assign bank[c*CH_SPAN + b] = 8'h00;
            end
        end
    end

    bmdma_rdmux #(.NCH(NCH)) u_rdmux (
        .bank  (bank),
        .addr  (addr),
        .size  (size),
        .rdata (rdata)
    );

endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk
    import bmdma_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic                clk,
    input logic                rst,
    input logic [NCH-1:0]      dma_start,
    input logic [NCH-1:0]      dma_abort,
    input logic [NCH-1:0]      dma_done,
    input logic [NCH-1:0]      irq,
    input logic [NCH-1:0][7:0] cmd_q,
    input logic [NCH-1:0][7:0] sts_q
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // R1
        reset_state_chk: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (cmd_q[c] == 8'h00 && sts_q[c] == STS_RESET && !dma_start[c] && !dma_abort[c]));

        // R3
        start_sets_act_chk: assert property (@(posedge clk) disable iff (rst)
            dma_start[c] |-> (sts_q[c][STS_ACT] && cmd_q[c][CMD_RUN]));

        // R4
        abort_clears_act_chk: assert property (@(posedge clk) disable iff (rst)
            dma_abort[c] |-> (!sts_q[c][STS_ACT] && !cmd_q[c][CMD_RUN]));

        // R4
        no_start_and_abort_chk: assert property (@(posedge clk) disable iff (rst)
            !(dma_start[c] && dma_abort[c]));

        // R5
        dir_frozen_chk: assert property (@(posedge clk) disable iff (rst)
            $past(cmd_q[c][CMD_RUN]) |-> $stable(cmd_q[c][CMD_DIR]));

        // R6
        act_rise_by_hw_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(sts_q[c][STS_ACT]) |-> dma_start[c]);

        // R6
        act_fall_by_hw_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(sts_q[c][STS_ACT]) |-> (dma_abort[c] || $past(dma_done[c])));

        // R8
        done_completes_chk: assert property (@(posedge clk) disable iff (rst)
            dma_done[c] |=> (!cmd_q[c][CMD_RUN] && !sts_q[c][STS_ACT] && sts_q[c][STS_INT]
                             && !dma_start[c] && !dma_abort[c]));

        // R10
        irq_rise_on_done_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[c]) |-> $past(dma_done[c]));
    end

endmodule

bind bmdma_regs bmdma_regs_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dma_start (dma_start),
    .dma_abort (dma_abort),
    .dma_done  (dma_done),
    .irq       (irq),
    .cmd_q     (cmd_q),
    .sts_q     (sts_q)
);

// File: tb/test_bmdma_regs.sv
module test_bmdma_regs;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [1:0]  size = 2'b00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic [1:0]  dev_sel = 2'b00;
    logic [1:0]  dma_done = 2'b00;
    logic [1:0]  dma_start;
    logic [1:0]  dma_abort;
    logic [63:0] dma_ptr;
    logic [1:0]  dma_dev;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          is_abort;
        int          ch;
        logic [31:0] ptr;
        logic        dev;
    } ev_t;

    ev_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bmdma_regs i_bmdma_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .size      (size),
        .wdata     (wdata),
        .rdata     (rdata),
        .dev_sel   (dev_sel),
        .dma_done  (dma_done),
        .dma_start (dma_start),
        .dma_abort (dma_abort),
        .dma_ptr   (dma_ptr),
        .dma_dev   (dma_dev),
        .irq       (irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(logic [3:0] a, logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; size = s; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic hread(logic [3:0] a, logic [1:0] s, logic [31:0] exp, string req);
        @(negedge clk);
        addr = a; size = s;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic expect_ev(bit is_abort, int ch, logic [31:0] p, logic d);
        ev_t e;
        e.is_abort = is_abort; e.ch = ch; e.ptr = p; e.dev = d;
        exp_q.push_back(e);
    endtask

    task automatic pulse_done(int ch);
        @(negedge clk);
        dma_done[ch] = 1'b1;
        @(negedge clk);
        dma_done[ch] = 1'b0;
    endtask

    // Monitor: compare every start/abort pulse against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < 2; c++) begin
                if (dma_start[c] || dma_abort[c]) begin
                    if (exp_q.size() == 0) begin
                        chk("R3 R4 R8 unexpected pulse", 32'(c), 32'hFFFF_FFFF);
                    end else begin
                        ev_t e;
                        e = exp_q.pop_front();
                        chk("R3 R4 channel", 32'(c), 32'(e.ch));
                        chk("R3 R4 kind", {31'b0, dma_abort[c]}, {31'b0, e.is_abort});
                        chk("R3 R4 dev", {31'b0, dma_dev[c]}, {31'b0, e.dev});
                        if (!e.is_abort)
                            chk("R3 ptr", dma_ptr[c*32 +: 32], e.ptr);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        hread(4'h0, 2'b00, 32'h00, "R1 cmd0");
        hread(4'h2, 2'b00, 32'h60, "R1 sts0");
        hread(4'h4, 2'b10, 32'h0, "R1 ptr0");
        hread(4'hA, 2'b00, 32'h60, "R1 sts1");
        chk("R1 irq", {30'b0, irq}, 32'h0);

        // R9 pointer low bits and size filtering
        hwrite(4'h4, 2'b10, 32'h1234_5677);
        hread(4'h4, 2'b10, 32'h1234_5674, "R9 ptr low bits");
        hwrite(4'h4, 2'b00, 32'h0000_00FF);
        hread(4'h4, 2'b10, 32'h1234_5674, "R9 byte ptr write ignored");
        hwrite(4'h0, 2'b01, 32'h0000_0001);
        hread(4'h0, 2'b00, 32'h00, "R9 half cmd write ignored");
        hwrite(4'h2, 2'b01, 32'h0000_00FF);
        hread(4'h2, 2'b00, 32'h60, "R9 half sts write ignored");

        // R3 start on channel 0, device 1, direction set
        dev_sel[0] = 1'b1;
        expect_ev(1'b0, 0, 32'h1234_5674, 1'b1);
        hwrite(4'h0, 2'b00, 32'h09);
        hread(4'h0, 2'b00, 32'h09, "R3 cmd0 running");
        hread(4'h2, 2'b00, 32'h61, "R3 active set");
        // R2 multi-byte reads
        hread(4'h0, 2'b01, 32'h0000_0009, "R2 half read");
        hread(4'h0, 2'b10, 32'h0061_0009, "R2 word read");

        // R5 direction frozen while running
        hwrite(4'h0, 2'b00, 32'h01);
        hread(4'h0, 2'b00, 32'h09, "R5 dir held");

        // R6 R7 status write: active kept, flags W1C, upper bits plain
        hwrite(4'h2, 2'b00, 32'hFE);
        hread(4'h2, 2'b00, 32'hF9, "R6 R7 sts write");
        hwrite(4'h2, 2'b00, 32'h60);
        hread(4'h2, 2'b00, 32'h61, "R6 sts restore");

        // R4 stop: abort pulse, active cleared, dir still held
        expect_ev(1'b1, 0, 32'h0, 1'b1);
        hwrite(4'h0, 2'b00, 32'h00);
        hread(4'h0, 2'b00, 32'h08, "R4 R5 cmd after stop");
        hread(4'h2, 2'b00, 32'h60, "R4 active cleared");
        // R5 direction free when idle
        hwrite(4'h0, 2'b00, 32'h00);
        hread(4'h0, 2'b00, 32'h00, "R5 dir writable idle");

        // R11 channel 1 start, channel 0 untouched
        hwrite(4'hC, 2'b10, 32'hABCD_0000);
        dev_sel[1] = 1'b0;
        expect_ev(1'b0, 1, 32'hABCD_0000, 1'b0);
        hwrite(4'h8, 2'b00, 32'h01);
        hread(4'hA, 2'b00, 32'h61, "R3 sts1 active");
        hread(4'h2, 2'b00, 32'h60, "R11 sts0 unchanged");
        hread(4'h4, 2'b10, 32'h1234_5674, "R11 ptr0 unchanged");

        // R8 R10 completion on channel 1
        pulse_done(1);
        hread(4'h8, 2'b00, 32'h00, "R8 run cleared");
        hread(4'hA, 2'b00, 32'h64, "R8 int set");
        chk("R10 irq after done", {30'b0, irq}, 32'h2);

        // R7 W1C of interrupt
        hwrite(4'hA, 2'b00, 32'h60);
        hread(4'hA, 2'b00, 32'h64, "R7 int kept on 0");
        hwrite(4'hA, 2'b00, 32'h64);
        hread(4'hA, 2'b00, 32'h60, "R7 int cleared on 1");
        chk("R10 irq cleared", {30'b0, irq}, 32'h0);

        // R8 completion collides with a stop write on channel 0
        dev_sel[0] = 1'b0;
        expect_ev(1'b0, 0, 32'h1234_5674, 1'b0);
        hwrite(4'h0, 2'b00, 32'h01);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'h0; size = 2'b00; wdata = 32'h00;
        dma_done[0] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; dma_done[0] = 1'b0;
        repeat (2) @(negedge clk);
        hread(4'h0, 2'b00, 32'h00, "R8 collision cmd");
        hread(4'h2, 2'b00, 32'h64, "R8 collision sts");
        chk("R10 irq ch0", {30'b0, irq}, 32'h1);

        // R2 unmapped and out-of-range bytes
        hread(4'h1, 2'b00, 32'h0, "R2 gap byte");
        hread(4'hE, 2'b01, 32'h0000_ABCD, "R2 ptr1 upper half");
        hread(4'hF, 2'b10, 32'h0000_00AB, "R2 read past end");
        hread(4'h0, 2'b11, 32'h0, "R2 reserved size");

        repeat (2) @(negedge clk);
        chk("R3 R4 pending events", 32'(exp_q.size()), 32'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule